// File: doc/BRIEF.md
# Display Identification Block Validator

This block inspects a 128-byte display identification block as it streams past, one byte per accepted cycle, and decides whether it is well formed. It watches a fixed eight-byte opening pattern, a version byte and a revision byte at fixed offsets, and an 8-bit wrapping sum taken over every byte. It holds no copy of the data. Each check folds into a small sticky flag or an accumulator, so the verdict is ready as soon as the closing byte is seen.

A producer drives bytes with a valid qualifier and marks the final byte with a last flag. The cycle after that byte is accepted, the block raises a one-cycle verdict strobe. With it come a pass flag and a reason code that names the first rule broken. Between blocks all internal state clears by itself, so blocks may follow each other with no idle cycles.

Top module: `dispid_validator`

## Requirements
- R1: While reset is high and after it falls, with no byte yet accepted, out_valid, out_ok and out_reason are all 0.
- R2: Bytes at offsets 0 to 7 must read 0x00, 0xFF, 0xFF, 0xFF, 0xFF, 0xFF, 0xFF, 0x00. Any mismatch gives reason code 1.
- R3: The byte at offset 18 must equal 0x01. Otherwise the reason code is 2.
- R4: The byte at offset 19 must be 1, 2 or 3. A value of 0 or above 3 gives reason code 3.
- R5: The 8-bit wrapping sum of all 128 bytes must be 0x00. Otherwise the reason code is 4.
- R6: out_valid is high for exactly the one cycle after each clock edge that accepts a byte with in_last set, and is low in every other cycle.
- R7: A block that breaks no rule gives out_ok = 1 and reason code 0. out_ok is 1 exactly when the reported code is 0.
- R8: If in_last arrives on any byte other than the 128th accepted byte (fewer or more than 128), the reason code is 5. This code overrides every other code.
- R9: When several content rules fail, the reported code is the lowest-numbered one among 1 (header), 2 (version), 3 (revision) and 4 (sum).
- R10: A cycle with in_valid low changes neither the byte count, the flags nor the sum. A block sent with idle gaps gets the same verdict as the same block sent without gaps.
- R11: After each in_last byte all state returns to its start value. The next block is judged on its own, even directly after a failed block.
- R12: Between strobes, out_ok and out_reason keep the values from the most recent verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte qualifier |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a block (only looked at when in_valid is high) |
| out_valid | output | 1 | One-cycle verdict strobe |
| out_ok | output | 1 | Block passed every rule |
| out_reason | output | 3 | 0 ok, 1 header, 2 version, 3 revision, 4 sum, 5 length |

## Verification
A wrong byte position corrupts everything after it. A counter that is off by one misplaces the version and revision checks and shows up at the very next strobe as code 5 on a correct block, or as a wrong field code. A flag or sum that fails to clear affects only the following block, so back-to-back blocks with a failure followed by a good block are what expose it. That error shows one verdict later. A gap cycle that is not ignored shifts the count and appears as a length error at the end of the gapped block.

// File: rtl/dispid_pkg.sv
package dispid_pkg;

  typedef enum logic [2:0] {
    RSN_OK  = 3'd0,
    RSN_HDR = 3'd1,
    RSN_VER = 3'd2,
    RSN_REV = 3'd3,
    RSN_SUM = 3'd4,
    RSN_LEN = 3'd5
  } rsn_e;

  localparam int DEF_BLK_LEN = 128;
  localparam int DEF_HDR_LEN = 8;
  localparam int DEF_VER_POS = 18;
  localparam int DEF_REV_POS = 19;
  localparam int DEF_VER_VAL = 1;
  localparam int DEF_REV_MIN = 1;
  localparam int DEF_REV_MAX = 3;

endpackage

// File: rtl/dispid_pos_ctr.sv
module dispid_pos_ctr #(
  parameter int BLK_LEN = 128,
  parameter int CW      = $clog2(BLK_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          clr,
  output logic [CW-1:0] pos,
  output logic          at_end
);

  localparam logic [CW-1:0] POS_SAT  = CW'(BLK_LEN);
  localparam logic [CW-1:0] POS_LAST = CW'(BLK_LEN - 1);

  logic [CW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (step && clr) begin
      pos_q <= '0;
    end else if (step && (pos_q != POS_SAT)) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign pos    = pos_q;
  assign at_end = (pos_q == POS_LAST);

  // R8: count never runs past its saturation value
  a_r8_pos_bounded: assert property (@(posedge clk) disable iff (rst)
    pos_q <= POS_SAT);

  // R11: a closing byte restarts the position
  a_r11_pos_restart: assert property (@(posedge clk) disable iff (rst)
    (step && clr) |=> (pos_q == '0));

  // R10: idle cycles leave the position alone
  a_r10_pos_idle: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pos_q));

endmodule

// File: rtl/dispid_field_chk.sv
module dispid_field_chk #(
  parameter int HDR_LEN = 8,
  parameter int VER_POS = 18,
  parameter int REV_POS = 19,
  parameter int VER_VAL = 1,
  parameter int REV_MIN = 1,
  parameter int REV_MAX = 3,
  parameter int CW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          clr,
  input  logic [CW-1:0] pos,
  input  logic [7:0]    data,
  output logic          hdr_bad_nx,
  output logic          ver_bad_nx,
  output logic          rev_bad_nx
);

  localparam logic [CW-1:0] HDR_END_POS = CW'(HDR_LEN);
  localparam logic [CW-1:0] HDR_TAIL    = CW'(HDR_LEN - 1);
  localparam logic [CW-1:0] VPOS        = CW'(VER_POS);
  localparam logic [CW-1:0] RPOS        = CW'(REV_POS);
  localparam logic [7:0]    VVAL        = 8'(VER_VAL);
  localparam logic [7:0]    RLO         = 8'(REV_MIN);
  localparam logic [7:0]    RHI         = 8'(REV_MAX);

  logic       hdr_bad_q, ver_bad_q, rev_bad_q;
  logic [7:0] hdr_exp;
  logic       hdr_hit, ver_hit, rev_hit;

  // opening pattern: zero at both ends, all ones between
  always_comb begin
    if ((pos == '0) || (pos == HDR_TAIL)) hdr_exp = 8'h00;
    else                                  hdr_exp = 8'hFF;
  end

  assign hdr_hit = step && (pos < HDR_END_POS) && (data != hdr_exp);
  assign ver_hit = step && (pos == VPOS) && (data != VVAL);
  assign rev_hit = step && (pos == RPOS) && ((data < RLO) || (data > RHI));

  assign hdr_bad_nx = hdr_bad_q | hdr_hit;
  assign ver_bad_nx = ver_bad_q | ver_hit;
  assign rev_bad_nx = rev_bad_q | rev_hit;

  always_ff @(posedge clk) begin
    if (rst || (step && clr)) begin
      hdr_bad_q <= 1'b0;
      ver_bad_q <= 1'b0;
      rev_bad_q <= 1'b0;
    end else begin
      hdr_bad_q <= hdr_bad_nx;
      ver_bad_q <= ver_bad_nx;
      rev_bad_q <= rev_bad_nx;
    end
  end

  // R2: a header failure stays recorded until the block closes
  a_r2_hdr_sticky: assert property (@(posedge clk) disable iff (rst)
    (hdr_bad_q && !(step && clr)) |=> hdr_bad_q);

  // R3: the version flag only rises on the version position
  a_r3_ver_rise_pos: assert property (@(posedge clk) disable iff (rst)
    (!ver_bad_q && !(step && pos == VPOS)) |=> !ver_bad_q);

  // R4: the revision flag only rises on the revision position
  a_r4_rev_rise_pos: assert property (@(posedge clk) disable iff (rst)
    (!rev_bad_q && !(step && pos == RPOS)) |=> !rev_bad_q);

  // R11: every flag is clear after a closing byte
  a_r11_flags_clear: assert property (@(posedge clk) disable iff (rst)
    (step && clr) |=> (!hdr_bad_q && !ver_bad_q && !rev_bad_q));

endmodule

// File: rtl/dispid_sum_acc.sv
module dispid_sum_acc #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          clr,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] sum_nx
);

  logic [DW-1:0] acc_q;

  assign sum_nx = step ? (acc_q + data) : acc_q;

  always_ff @(posedge clk) begin
    if (rst || (step && clr)) begin
      acc_q <= '0;
    end else begin
      acc_q <= sum_nx;
    end
  end

  // R10: idle cycles leave the running sum untouched
  a_r10_sum_idle: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc_q));

  // R11: the running sum restarts after each closing byte
  a_r11_sum_clear: assert property (@(posedge clk) disable iff (rst)
    (step && clr) |=> (acc_q == '0));

endmodule

// File: rtl/dispid_validator.sv
module dispid_validator
  import dispid_pkg::*;
#(
  parameter int BLK_LEN = DEF_BLK_LEN,
  parameter int HDR_LEN = DEF_HDR_LEN,
  parameter int VER_POS = DEF_VER_POS,
  parameter int REV_POS = DEF_REV_POS,
  parameter int VER_VAL = DEF_VER_VAL,
  parameter int REV_MIN = DEF_REV_MIN,
  parameter int REV_MAX = DEF_REV_MAX
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  output logic       out_ok,
  output logic [2:0] out_reason
);

  localparam int CW = $clog2(BLK_LEN + 1);

  logic          fin;
  logic [CW-1:0] pos;
  logic          at_end;
  logic          hdr_bad, ver_bad, rev_bad;
  logic [7:0]    sum_nx;
  rsn_e          rsn_nx;
  logic          vld_q, ok_q;
  rsn_e          rsn_q;

  assign fin = in_valid && in_last;

  dispid_pos_ctr #(
    .BLK_LEN (BLK_LEN),
    .CW      (CW)
  ) u_pos (
    .clk    (clk),
    .rst    (rst),
    .step   (in_valid),
    .clr    (in_last),
    .pos    (pos),
    .at_end (at_end)
  );

  dispid_field_chk #(
    .HDR_LEN (HDR_LEN),
    .VER_POS (VER_POS),
    .REV_POS (REV_POS),
    .VER_VAL (VER_VAL),
    .REV_MIN (REV_MIN),
    .REV_MAX (REV_MAX),
    .CW      (CW)
  ) u_fld (
    .clk        (clk),
    .rst        (rst),
    .step       (in_valid),
    .clr        (in_last),
    .pos        (pos),
    .data       (in_data),
    .hdr_bad_nx (hdr_bad),
    .ver_bad_nx (ver_bad),
    .rev_bad_nx (rev_bad)
  );

  dispid_sum_acc #(
    .DW (8)
  ) u_sum (
    .clk    (clk),
    .rst    (rst),
    .step   (in_valid),
    .clr    (in_last),
    .data   (in_data),
    .sum_nx (sum_nx)
  );

  // length outranks content; content rules in fixed priority
  always_comb begin
    if (!at_end)             rsn_nx = RSN_LEN;
    else if (hdr_bad)        rsn_nx = RSN_HDR;
    else if (ver_bad)        rsn_nx = RSN_VER;
    else if (rev_bad)        rsn_nx = RSN_REV;
    else if (sum_nx != 8'h0) rsn_nx = RSN_SUM;
    else                     rsn_nx = RSN_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
      rsn_q <= RSN_OK;
    end else begin
      vld_q <= fin;
      if (fin) begin
        ok_q  <= (rsn_nx == RSN_OK);
        rsn_q <= rsn_nx;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_ok     = ok_q;
  assign out_reason = rsn_q;

  // R6: a closing byte yields a strobe on the next cycle
  a_r6_strobe_after_last: assert property (@(posedge clk) disable iff (rst)
    fin |=> out_valid);

  // R6: no strobe without a closing byte
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !fin |=> !out_valid);

  // R7: pass flag agrees with the reason code
  a_r7_ok_matches_code: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ok == (out_reason == 3'd0)));

  // R12: verdict fields hold between strobes
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !fin |=> ($stable(out_ok) && $stable(out_reason)));

  // R8: reason code stays inside the defined set
  a_r8_code_range: assert property (@(posedge clk) disable iff (rst)
    out_reason <= 3'd5);

endmodule

// File: tb/tb_dispid_validator.sv
module tb_dispid_validator;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_last;
  logic       out_valid;
  logic       out_ok;
  logic [2:0] out_reason;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0] q[$];
  logic       exp_valid = 1'b0;
  logic       exp_ok    = 1'b0;
  logic [2:0] exp_rsn   = 3'd0;
  string      tag       = "R1";

  logic [7:0] blk [0:199];

  always #10 clk = ~clk;

  dispid_validator dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_last    (in_last),
    .out_valid  (out_valid),
    .out_ok     (out_ok),
    .out_reason (out_reason)
  );

  function automatic logic [2:0] ref_verdict();
    logic [7:0] s;
    if (q.size() != 128) return 3'd5;
    for (int i = 0; i < 8; i++) begin
      if (q[i] != (((i == 0) || (i == 7)) ? 8'h00 : 8'hFF)) return 3'd1;
    end
    if (q[18] != 8'd1) return 3'd2;
    if ((q[19] < 8'd1) || (q[19] > 8'd3)) return 3'd3;
    s = 8'h00;
    foreach (q[i]) s = s + q[i];
    if (s != 8'h00) return 3'd4;
    return 3'd0;
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s out_valid act=%0d exp=%0d", tag, out_valid, exp_valid);
    end
    checks++;
    if ((out_ok !== exp_ok) || (out_reason !== exp_rsn)) begin
      errors++;
      $display("FAIL %s ok/reason act=%0d/%0d exp=%0d/%0d", tag,
               out_ok, out_reason, exp_ok, exp_rsn);
    end
  endtask

  // drive one cycle, update model, sample after the edge
  task automatic cyc(input logic v, input logic [7:0] d, input logic l);
    in_valid = v;
    in_data  = d;
    in_last  = l;
    exp_valid = 1'b0;
    if (v) begin
      q.push_back(d);
      if (l) begin
        exp_rsn   = ref_verdict();
        exp_ok    = (exp_rsn == 3'd0);
        exp_valid = 1'b1;
        q.delete();
      end
    end
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic send(input int n, input bit gaps, input string t);
    tag = t;
    for (int i = 0; i < n; i++) begin
      if (gaps && ((i % 5) == 3)) begin
        cyc(1'b0, 8'hA5, 1'b1);   // idle cycle with junk that must be ignored
        cyc(1'b0, 8'h3C, 1'b0);
      end
      cyc(1'b1, blk[i], (i == n - 1));
    end
    cyc(1'b0, 8'h00, 1'b0);
  endtask

  task automatic fix_sum();
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 127; i++) s = s + blk[i];
    blk[127] = 8'h00 - s;
  endtask

  task automatic make_good(input logic [7:0] rev);
    for (int i = 0; i < 200; i++) blk[i] = 8'((i * 37 + 11) & 8'hFF);
    blk[0] = 8'h00;
    for (int i = 1; i < 7; i++) blk[i] = 8'hFF;
    blk[7]  = 8'h00;
    blk[18] = 8'h01;
    blk[19] = rev;
    fix_sum();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired during %s", tag);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    compare();
    rst = 1'b0;
    cyc(1'b0, 8'h00, 1'b0);

    make_good(8'd3); send(128, 1'b0, "R7");
    make_good(8'd1); send(128, 1'b1, "R10");
    make_good(8'd2); blk[3] = 8'hFE; fix_sum(); send(128, 1'b0, "R2");
    make_good(8'd2); blk[0] = 8'h01; fix_sum(); send(128, 1'b0, "R2");
    make_good(8'd2); blk[7] = 8'hFF; fix_sum(); send(128, 1'b0, "R2");
    make_good(8'd2); blk[18] = 8'h02; fix_sum(); send(128, 1'b0, "R3");
    make_good(8'd0); send(128, 1'b0, "R4");
    make_good(8'd4); send(128, 1'b0, "R4");
    make_good(8'd3); blk[60] = blk[60] + 8'd1; send(128, 1'b0, "R5");
    make_good(8'd3); blk[5] = 8'h00; send(128, 1'b0, "R9");
    make_good(8'd9); blk[18] = 8'h00; send(128, 1'b0, "R9");
    make_good(8'd3); send(10, 1'b0, "R8");
    make_good(8'd3); send(130, 1'b0, "R8");
    make_good(8'd3); send(127, 1'b0, "R8");
    make_good(8'd3); send(1, 1'b0, "R6");

    // back-to-back: failing block directly followed by a good one
    make_good(8'd3); blk[2] = 8'h00; tag = "R11";
    for (int i = 0; i < 128; i++) cyc(1'b1, blk[i], (i == 127));
    make_good(8'd3);
    for (int i = 0; i < 128; i++) cyc(1'b1, blk[i], (i == 127));
    tag = "R12";
    repeat (4) cyc(1'b0, 8'hFF, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule